// File: doc/BRIEF.md
# Configuration Register Write Protection Unit

This block holds a bank of memory-bus timing configuration registers and shields them from accidental software writes. For each chip-select set it keeps four words: setup, pulse, cycle and bus mode. Next to the bank sit two control words. The lock-control register carries a single enable bit. The status register records any write that the lock refused.

While the lock is off, the bank behaves as plain read/write storage. While the lock is on, any write aimed at a bank register is refused and the stored word stays as it was. The refusal sets a sticky violation flag, and a source field records the address that was targeted. Software reads the status register to learn what happened, and that read clears the flag. The lock-control register can always be written, so the lock can be released again.

The bus has separate write and read addresses, so that a write and a read can fall in the same cycle. Read data is registered and appears one cycle after the read strobe. The address map is derived from the parameters:
- Bank register `k` of set `s` sits at address `4*s+k`, where `k` is 0 for setup, 1 for pulse, 2 for cycle and 3 for bus mode.
- The lock-control register sits at `4*NUM_SETS`.
- The status register sits at `4*NUM_SETS+1`.
- All higher addresses are unmapped.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset, every bank register, the lock enable, the violation flag, the source field and `rdData` are all zero.
- R2: With the lock off, a write to a bank address (below `4*NUM_SETS`) stores `wrData`, and a later read of that address returns it.
- R3: The lock-control register at `4*NUM_SETS` is always writable and holds the lock enable in bit 0. A read returns that bit in bit 0 and zeros elsewhere. Writing 0 releases an active lock.
- R4: With the lock on, a write to a bank address leaves the stored word unchanged.
- R5: With the lock on, a write to a bank address sets the violation flag and loads the source field with the targeted address. In the status word at `4*NUM_SETS+1`, the flag is bit 0 and the source field starts at bit 8.
- R6: If several refused writes occur before the status is read, the source field holds the address of the most recent one.
- R7: A status read returns the flag and source as they stood before the read. It then clears the flag. The source field keeps its value.
- R8: If a status read and a refused write occur in the same cycle, the flag stays set and the source field takes the new address.
- R9: Writes to the lock-control register, to the status register or to unmapped addresses, and any write while the lock is off, leave the flag and the source field unchanged.
- R10: `rdData` loads one cycle after `rdEn` and holds its value while `rdEn` is low. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W = clog2(4*NUM_SETS+2) | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data |

## Verification
The bench builds the block with three chip-select sets and 16-bit data. This gives a bank size that is not a power of two. The lock-control register lands at 12 and the status register at 13, which leaves addresses 14 and 15 unmapped but still reachable. That is what makes the boundary between protected, control and unmapped addresses testable. The 16-bit width still holds the 4-bit source field at bit 8. The vector table walks lock on/off transitions, refused writes to the first, last and a middle bank register, and clear-on-read. Directed tests then cover the same-cycle read and refusal clash and the hold behaviour of the read port.

// File: rtl/cfg_write_guard_pkg.sv
package cfg_write_guard_pkg;

  // Words kept per chip-select set: setup, pulse, cycle, bus mode
  localparam int REGS_PER_SET = 4;
  // Field positions inside the control words
  localparam int LOCK_EN_BIT  = 0;
  localparam int VIOL_BIT     = 0;
  localparam int SRC_LSB      = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWe;    // commit a bank write
    logic rdLoad;   // load the read register this cycle
    logic selCfg;   // read source: bank
    logic selLock;  // read source: lock control
    logic selStat;  // read source: status
  } guard_strobe_t;

endpackage

// File: rtl/cfg_write_guard_ctrl.sv
module cfg_write_guard_ctrl
  import cfg_write_guard_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrLockBit,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output guard_strobe_t     strb,
  output logic              protEn,
  output logic              violFlag,
  output logic [ADDR_W-1:0] violSrc
);

  localparam int NUM_REGS = NUM_SETS * REGS_PER_SET;
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_REGS + 1);

  // Address classification
  logic wrInBank, wrToLock, rdInBank, rdToLock, rdToStat;
  logic refused, statRead;

  assign wrInBank = wrAddr < LOCK_A;
  assign wrToLock = wrAddr == LOCK_A;
  assign rdInBank = rdAddr < LOCK_A;
  assign rdToLock = rdAddr == LOCK_A;
  assign rdToStat = rdAddr == STAT_A;

  // Protection decision
  assign refused  = wrEn && wrInBank && protEn;
  assign statRead = rdEn && rdToStat;

  always_comb begin
    strb         = '0;
    strb.cfgWe   = wrEn && wrInBank && !protEn;
    strb.rdLoad  = rdEn;
    strb.selCfg  = rdInBank;
    strb.selLock = rdToLock;
    strb.selStat = rdToStat;
  end

  // Lock control: always writable
  always_ff @(posedge clk) begin
    if (rst)                      protEn <= 1'b0;
    else if (wrEn && wrToLock)    protEn <= wrLockBit;
  end

  // Violation record: a refusal takes priority over a clearing read
  always_ff @(posedge clk) begin
    if (rst) begin
      violFlag <= 1'b0;
      violSrc  <= '0;
    end else if (refused) begin
      violFlag <= 1'b1;
      violSrc  <= wrAddr;
    end else if (statRead) begin
      violFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_write_guard_dp.sv
module cfg_write_guard_dp
  import cfg_write_guard_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  guard_strobe_t     strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              protEn,
  input  logic              violFlag,
  input  logic [ADDR_W-1:0] violSrc,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_REGS = NUM_SETS * REGS_PER_SET;

  logic [DATA_W-1:0] cfgMem [NUM_REGS];

  // One storage word per set and register kind
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar k = 0; k < REGS_PER_SET; k++) begin : g_reg
      localparam int IDX = s * REGS_PER_SET + k;
      logic [DATA_W-1:0] word;
      always_ff @(posedge clk) begin
        if (rst)
          word <= '0;
        else if (strb.cfgWe && wrAddr == ADDR_W'(IDX))
          word <= wrData;
      end
      assign cfgMem[IDX] = word;
    end
  end

  // Read selection
  logic [DATA_W-1:0] cfgRd, lockWord, statWord, rdNext;

  always_comb begin
    cfgRd = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) cfgRd = cfgMem[i];
  end

  always_comb begin
    lockWord              = '0;
    lockWord[LOCK_EN_BIT] = protEn;
    statWord                     = '0;
    statWord[VIOL_BIT]           = violFlag;
    statWord[SRC_LSB +: ADDR_W]  = violSrc;
  end

  always_comb begin
    if (strb.selCfg)       rdNext = cfgRd;
    else if (strb.selLock) rdNext = lockWord;
    else if (strb.selStat) rdNext = statWord;
    else                   rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strb.rdLoad) rdData <= rdNext;
  end

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import cfg_write_guard_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_SETS * REGS_PER_SET + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  guard_strobe_t     strb;
  logic              protEn;
  logic              violFlag;
  logic [ADDR_W-1:0] violSrc;

  cfg_write_guard_ctrl #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLockBit(wrData[LOCK_EN_BIT]), .rdEn(rdEn), .rdAddr(rdAddr),
    .strb(strb), .protEn(protEn), .violFlag(violFlag), .violSrc(violSrc)
  );

  cfg_write_guard_dp #(.NUM_SETS(NUM_SETS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .protEn(protEn), .violFlag(violFlag), .violSrc(violSrc),
    .rdData(rdData)
  );

endmodule

// File: rtl/cfg_write_guard_chk.sv
module cfg_write_guard_chk
  import cfg_write_guard_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input guard_strobe_t     strb,
  input logic              protEn,
  input logic              violFlag,
  input logic [ADDR_W-1:0] violSrc
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(NUM_SETS * REGS_PER_SET);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_SETS * REGS_PER_SET + 1);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!protEn && !violFlag && violSrc == '0 && rdData == '0));

  // R3
  lock_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == LOCK_A) |=> (protEn == $past(wrData[LOCK_EN_BIT])));

  // R4
  blocked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (protEn && wrEn) |-> !strb.cfgWe);

  // R5
  viol_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (protEn && wrEn && wrAddr < LOCK_A) |=> (violFlag && violSrc == $past(wrAddr)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == STAT_A && !(protEn && wrEn && wrAddr < LOCK_A))
      |=> (!violFlag && $stable(violSrc)));

  // R8
  clash_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == STAT_A && protEn && wrEn && wrAddr < LOCK_A) |=> violFlag);

  // R9
  quiet_status_chk: assert property (@(posedge clk) disable iff (rst)
    (!(protEn && wrEn && wrAddr < LOCK_A) && !(rdEn && rdAddr == STAT_A))
      |=> ($stable(violFlag) && $stable(violSrc)));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

endmodule

bind cfg_write_guard cfg_write_guard_chk #(
  .NUM_SETS(NUM_SETS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .strb(strb),
  .protEn(protEn), .violFlag(violFlag), .violSrc(violSrc)
);

// File: tb/cfg_write_guard_test.sv
`timescale 1ns/1ps
module cfg_write_guard_test;

  localparam int NS = 3;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [AW-1:0] LOCK_A = 4'd12;
  localparam logic [AW-1:0] STAT_A = 4'd13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_write_guard #(.NUM_SETS(NS), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  // Status word: flag bit 0, source address at bit 8
  typedef struct packed {
    logic          isRd;
    logic [3:0]    req;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2,  4'd0,  16'h1111},  // R2 write, lock off
    '{1'b0, 4'd2,  4'd5,  16'h2222},  // R2
    '{1'b1, 4'd2,  4'd0,  16'h1111},  // R2 readback
    '{1'b1, 4'd2,  4'd5,  16'h2222},  // R2
    '{1'b0, 4'd3,  4'd12, 16'h0001},  // R3 lock on
    '{1'b1, 4'd3,  4'd12, 16'h0001},  // R3 readback
    '{1'b0, 4'd4,  4'd0,  16'hDEAD},  // R4 refused
    '{1'b1, 4'd4,  4'd0,  16'h1111},  // R4 unchanged
    '{1'b1, 4'd5,  4'd13, 16'h0001},  // R5 flag set, source 0
    '{1'b1, 4'd7,  4'd13, 16'h0000},  // R7 flag cleared
    '{1'b0, 4'd6,  4'd11, 16'hBEEF},  // R6 refused
    '{1'b0, 4'd6,  4'd5,  16'h3333},  // R6 refused, newest
    '{1'b1, 4'd6,  4'd13, 16'h0501},  // R6 source = 5
    '{1'b1, 4'd4,  4'd5,  16'h2222},  // R4 unchanged
    '{1'b0, 4'd3,  4'd12, 16'h0000},  // R3 lock released
    '{1'b0, 4'd2,  4'd11, 16'h4444},  // R2 write accepted again
    '{1'b1, 4'd2,  4'd11, 16'h4444},  // R2
    '{1'b1, 4'd9,  4'd13, 16'h0500}   // R9 open write left status alone
  };

  initial begin : main
    logic [DW-1:0] v;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 16'h0000);
    rst = 1'b0;
    doRead(LOCK_A, v); check("R1 lock", v, 16'h0000);
    doRead(STAT_A, v); check("R1 status", v, 16'h0000);
    doRead(4'd7, v);   check("R1 bank", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        doRead(VECS[i].addr, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].data);
      end else begin
        doWrite(VECS[i].addr, VECS[i].data);
      end
    end

    // R9: with lock on, writes to control/unmapped space leave status alone
    doWrite(LOCK_A, 16'h0001);
    doWrite(4'd2, 16'h0BAD);          // refused, source 2
    doRead(STAT_A, v); check("R5 source 2", v, 16'h0201);
    doWrite(STAT_A, 16'hFFFF);
    doWrite(4'd14, 16'h1234);
    doWrite(LOCK_A, 16'h0001);
    doRead(STAT_A, v); check("R9 status quiet", v, 16'h0200);
    doRead(4'd14, v);  check("R10 unmapped read", v, 16'h0000);

    // R8: status read and refused write in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd9; wrData = 16'h5555;
    rdEn = 1'b1; rdAddr = STAT_A;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R8 read shows old value", rdData, 16'h0200);
    doRead(STAT_A, v); check("R8 flag kept, source 9", v, 16'h0901);
    doRead(4'd9, v);   check("R4 bank 9 unchanged", v, 16'h0000);

    // R10: read data holds while rdEn low
    doRead(4'd11, v);
    held = v;
    repeat (3) @(negedge clk);
    check("R10 hold", rdData, held);

    // R3: last bank word and release while locked
    doWrite(LOCK_A, 16'hFFFE);
    doRead(LOCK_A, v); check("R3 lock released", v, 16'h0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule